// File: doc/BRIEF.md
# Three-Phase Output Reference Generator with Common-Mode Injection

This block turns a pair of phase angles into the three signed voltage references that a matrix-converter modulator tracks. Each accepted input sample carries an output angle, an input (supply) angle, an output magnitude, a fixed phase offset and an injection enable. Angles are unsigned fractions of one electrical turn. The block evaluates three sines spaced one third of a turn apart and scales them by the magnitude. The three results come out together with a one-cycle strobe, a fixed number of cycles after the sample was taken.

When injection is enabled, one shared correction is added to all three unit sines before scaling. It is one sixth of the sine of three times the output angle, minus the sine of three times the input angle divided by two root three. Because every phase receives the same correction, the line-to-line differences do not change. The phase references are flattened so that a larger output fits inside the input voltage envelope: the usable ratio rises from one half of the input amplitude to about 0.87 of it. Generating the angles is the job of the surrounding logic.

Top module: `orefgen_top`

## Requirements
- R1: While reset is low, and in the first cycle after it, `out_valid` is 0 and all three references read 0.
- R2: `out_valid` is high exactly 3 clock cycles after the cycle in which `in_valid` was sampled high, whatever the state of `cm_en`.
- R3: With `cm_en`=0, `ref_a` equals mag·sin(2π·(theta_out+phase_ofs)/2^16) within 24 LSB. Angles are unsigned 16-bit turn fractions. `mag` is unsigned with 32768 meaning 1.0. The references are signed 16-bit with 32768 meaning 1.0.
- R4: `ref_b` and `ref_c` follow the same rule as `ref_a`, but with the angle reduced by 21845 and 43691 (one third and two thirds of a turn, modulo 2^16).
- R5: With `cm_en`=0 and `mag` at most 32768, the sum of the three references stays within 48 LSB of zero.
- R6: With `cm_en`=1, every unit sine is increased by sin(3·theta_out)/6 − sin(3·theta_in)/(2√3) before scaling, with triple angles taken modulo 2^16. With `cm_en`=0, `theta_in` has no effect on any output.
- R7: For the same inputs with no saturation, the differences ref_a−ref_b and ref_b−ref_c with injection on and with injection off agree within 2 LSB.
- R8: The unit value (sine plus correction) is clamped to [−32768, 32767] before scaling. A unit overflow therefore gives mag·32767/32768 on the positive side, and −mag on the negative side.
- R9: The scaled result is clamped to the signed 16-bit range. No reference magnitude exceeds `mag`.
- R10: The references change only in a cycle where `out_valid` is high. At all other times they hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Sample strobe for all inputs below |
| theta_out | input | 16 | Output angle, fraction of a turn |
| theta_in | input | 16 | Input supply angle, fraction of a turn |
| phase_ofs | input | 16 | Initial phase offset added to the output angle |
| mag | input | 16 | Output magnitude, unsigned, 32768 = 1.0 |
| cm_en | input | 1 | Add the common-mode correction when high |
| ref_a | output | 16 | Phase a reference, signed |
| ref_b | output | 16 | Phase b reference, signed |
| ref_c | output | 16 | Phase c reference, signed |
| out_valid | output | 1 | High for one cycle per result |

## Verification
The bench builds the block with the default 16-bit angle and 16-bit sample widths. At these widths a double-precision sine in the bench gives a fine reference, and a 24-LSB window leaves room for the polynomial's error while still catching a wrong offset or a missing correction. The same widths let specific angles drive the unit sum into overflow on both sides: one sample places a peak of phase a on a positive correction, and another places a trough on a negative one. A magnitude near 2.0 exercises output clamping. A pair of samples that differ only in the input angle, and a pair that differ only in the injection enable, bring the phase-independence and line-difference properties within reach.

// File: rtl/orefgen_pkg.sv
package orefgen_pkg;

  parameter int ANG_W = 16;
  parameter int DAT_W = 16;

  localparam int     FB  = DAT_W - 1;
  localparam int     QB  = ANG_W - 2;
  localparam longint ONE = longint'(1) <<< FB;

  // odd-power series for sin(pi/2 * x), coefficients held at 15 fraction bits then rescaled
  localparam longint C1 = (longint'(51472) * ONE) >>> 15;
  localparam longint C3 = (longint'(21167) * ONE) >>> 15;
  localparam longint C5 = (longint'(2611)  * ONE) >>> 15;
  localparam longint C7 = (longint'(153)   * ONE) >>> 15;

  localparam longint K_SIXTH    = ONE / 6;
  localparam longint K_HALF_RT3 = (ONE * 577350) / 2000000;

  localparam logic [ANG_W-1:0] THIRD_TURN = ANG_W'(((longint'(1) <<< ANG_W) + 1) / 3);
  localparam logic [ANG_W-1:0] TWO_THIRDS = ANG_W'(((longint'(2) <<< ANG_W) + 1) / 3);

  typedef logic        [ANG_W-1:0] angle_t;
  typedef logic signed [DAT_W-1:0] sample_t;
  typedef logic        [DAT_W-1:0] mag_t;

  function automatic angle_t triple(input angle_t a);
    return a + (a << 1);
  endfunction

  function automatic sample_t sat_fn(input longint v);
    if (v > ONE - 1) return sample_t'(ONE - 1);
    if (v < -ONE)    return sample_t'(-ONE);
    return sample_t'(v);
  endfunction

  function automatic sample_t unit_sine(input angle_t a);
    logic [1:0] quad;
    longint     frac, x, x2, p, y;
    quad = a[ANG_W-1 -: 2];
    frac = longint'(a[QB-1:0]);
    if (quad[0]) frac = (longint'(1) <<< QB) - frac;
    x  = (frac * ONE) >>> QB;
    x2 = (x * x) >>> FB;
    p  = (C7 * x2) >>> FB;
    p  = C5 - p;
    p  = (p * x2) >>> FB;
    p  = C3 - p;
    p  = (p * x2) >>> FB;
    p  = C1 - p;
    y  = (p * x) >>> FB;
    if (y > ONE - 1) y = ONE - 1;
    if (quad[1]) y = -y;
    return sample_t'(y);
  endfunction

  function automatic longint cm_value(input sample_t s3o, input sample_t s3i);
    return (longint'(s3o) * K_SIXTH - longint'(s3i) * K_HALF_RT3) >>> FB;
  endfunction

  function automatic sample_t scale_fn(input sample_t u, input mag_t m);
    return sat_fn((longint'(u) * longint'(m)) >>> FB);
  endfunction

endpackage

// File: rtl/orefgen_sine.sv
module orefgen_sine
  import orefgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    en,
  input  angle_t  ang,
  output sample_t y
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  y <= '0;
    else if (en) y <= unit_sine(ang);
  end

endmodule

// File: rtl/orefgen_cm_mix.sv
module orefgen_cm_mix
  import orefgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  logic    cm_en,
  input  mag_t    mag_in,
  input  sample_t ua,
  input  sample_t ub,
  input  sample_t uc,
  input  sample_t s3o,
  input  sample_t s3i,
  output sample_t ma,
  output sample_t mb,
  output sample_t mc,
  output logic    out_valid,
  output mag_t    mag_out,
  output logic    cm_out
);

  sample_t u_in  [3];
  sample_t u_nxt [3];
  sample_t u_q   [3];
  longint  cm_term;

  assign u_in[0] = ua;
  assign u_in[1] = ub;
  assign u_in[2] = uc;

  always_comb begin
    cm_term = cm_en ? cm_value(s3o, s3i) : longint'(0);
    for (int k = 0; k < 3; k++) u_nxt[k] = sat_fn(longint'(u_in[k]) + cm_term);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 3; k++) u_q[k] <= '0;
      out_valid <= 1'b0;
      mag_out   <= '0;
      cm_out    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        for (int k = 0; k < 3; k++) u_q[k] <= u_nxt[k];
        mag_out <= mag_in;
        cm_out  <= cm_en;
      end
    end
  end

  assign ma = u_q[0];
  assign mb = u_q[1];
  assign mc = u_q[2];

endmodule

// File: rtl/orefgen_scale.sv
module orefgen_scale
  import orefgen_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    in_valid,
  input  mag_t    mag,
  input  sample_t ua,
  input  sample_t ub,
  input  sample_t uc,
  output sample_t ra,
  output sample_t rb,
  output sample_t rc,
  output logic    out_valid
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ra <= '0;
      rb <= '0;
      rc <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        ra <= scale_fn(ua, mag);
        rb <= scale_fn(ub, mag);
        rc <= scale_fn(uc, mag);
      end
    end
  end

endmodule

// File: rtl/orefgen_top.sv
module orefgen_top
  import orefgen_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  input  logic [ANG_W-1:0]        theta_out,
  input  logic [ANG_W-1:0]        theta_in,
  input  logic [ANG_W-1:0]        phase_ofs,
  input  logic [DAT_W-1:0]        mag,
  input  logic                    cm_en,
  output logic signed [DAT_W-1:0] ref_a,
  output logic signed [DAT_W-1:0] ref_b,
  output logic signed [DAT_W-1:0] ref_c,
  output logic                    out_valid
);

  localparam int NSIN = 5;

  angle_t  base_ang;
  angle_t  ang_s0 [NSIN];
  sample_t sin_s1 [NSIN];

  logic    s1_valid, s1_cm;
  mag_t    s1_mag;
  logic    s2_valid, s2_cm;
  mag_t    s2_mag;
  sample_t u2_a, u2_b, u2_c;

  always_comb begin
    base_ang  = theta_out + phase_ofs;
    ang_s0[0] = base_ang;
    ang_s0[1] = base_ang - THIRD_TURN;
    ang_s0[2] = base_ang - TWO_THIRDS;
    ang_s0[3] = triple(theta_out);
    ang_s0[4] = triple(theta_in);
  end

  // stage 1: five sine evaluators (three phases, two triple angles)
  for (genvar g = 0; g < NSIN; g++) begin : g_sine
    orefgen_sine u_sin (
      .clk (clk),
      .rst_n (rst_n),
      .en  (in_valid),
      .ang (ang_s0[g]),
      .y   (sin_s1[g])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_cm    <= 1'b0;
      s1_mag   <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid) begin
        s1_cm  <= cm_en;
        s1_mag <= mag;
      end
    end
  end

  // stage 2: common-mode add and unit clamp
  orefgen_cm_mix u_mix (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s1_valid),
    .cm_en     (s1_cm),
    .mag_in    (s1_mag),
    .ua        (sin_s1[0]),
    .ub        (sin_s1[1]),
    .uc        (sin_s1[2]),
    .s3o       (sin_s1[3]),
    .s3i       (sin_s1[4]),
    .ma        (u2_a),
    .mb        (u2_b),
    .mc        (u2_c),
    .out_valid (s2_valid),
    .mag_out   (s2_mag),
    .cm_out    (s2_cm)
  );

  // stage 3: magnitude scaling into the output registers
  orefgen_scale u_scale (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (s2_valid),
    .mag       (s2_mag),
    .ua        (u2_a),
    .ub        (u2_b),
    .uc        (u2_c),
    .ra        (ref_a),
    .rb        (ref_b),
    .rc        (ref_c),
    .out_valid (out_valid)
  );

endmodule

// File: rtl/orefgen_chk.sv
module orefgen_chk
  import orefgen_pkg::*;
(
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_valid,
  input logic                    out_valid,
  input logic signed [DAT_W-1:0] ref_a,
  input logic signed [DAT_W-1:0] ref_b,
  input logic signed [DAT_W-1:0] ref_c,
  input logic [DAT_W-1:0]        s2_mag,
  input logic                    s2_cm
);

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && ref_a == 0 && ref_b == 0 && ref_c == 0));

  // R2
  latency_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(in_valid, 3));

  // R5
  balanced_sum_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !$past(s2_cm) && int'({1'b0, $past(s2_mag)}) <= int'(ONE))
    |-> iabs(int'(ref_a) + int'(ref_b) + int'(ref_c)) <= 48);

  // R9
  mag_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (iabs(int'(ref_a)) <= int'({1'b0, $past(s2_mag)}) &&
                   iabs(int'(ref_b)) <= int'({1'b0, $past(s2_mag)}) &&
                   iabs(int'(ref_c)) <= int'({1'b0, $past(s2_mag)})));

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(ref_a) && $stable(ref_b) && $stable(ref_c)));

endmodule

bind orefgen_top orefgen_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .out_valid (out_valid),
  .ref_a     (ref_a),
  .ref_b     (ref_b),
  .ref_c     (ref_c),
  .s2_mag    (s2_mag),
  .s2_cm     (s2_cm)
);

// File: tb/tb_orefgen_top.sv
`timescale 1ns/1ps
module tb_orefgen_top;

  localparam real PI  = 3.14159265358979;
  localparam int  TOL = 24;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] theta_out = '0, theta_in = '0, phase_ofs = '0, mag = '0;
  logic        cm_en = 1'b0;
  logic signed [15:0] ref_a, ref_b, ref_c;
  logic        out_valid;

  orefgen_top dut (
    .clk (clk), .rst_n (rst_n), .in_valid (in_valid),
    .theta_out (theta_out), .theta_in (theta_in), .phase_ofs (phase_ofs),
    .mag (mag), .cm_en (cm_en),
    .ref_a (ref_a), .ref_b (ref_b), .ref_c (ref_c), .out_valid (out_valid)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  typedef struct { real ea, eb, ec; int stamp; bit cm; int seq; } exp_t;
  exp_t sb[$];
  int got_a [64], got_b [64], got_c [64];
  int checks = 0, errors = 0, next_seq = 0, popped = 0;
  bit done = 1'b0;

  function automatic int iabs(input int v);
    return (v < 0) ? -v : v;
  endfunction

  function automatic real usin(input int ang);
    int a;
    a = ((ang % 65536) + 65536) % 65536;
    return $sin(2.0 * PI * a / 65536.0);
  endfunction

  function automatic real model(input int ang, input real cmv, input int vo);
    real u, r;
    u = usin(ang) + cmv;
    if (u > 32767.0 / 32768.0) u = 32767.0 / 32768.0;
    if (u < -1.0) u = -1.0;
    r = u * vo;
    if (r > 32767.0) r = 32767.0;
    if (r < -32768.0) r = -32768.0;
    return r;
  endfunction

  task automatic chk(input bit ok, input string tag, input string what, input int act, input int expv);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  task automatic send(input int to, input int po, input int ti, input int vo, input bit cm, output int seq);
    exp_t e;
    real cmv;
    cmv = cm ? (usin(3 * to) / 6.0 - usin(3 * ti) / (2.0 * $sqrt(3.0))) : 0.0;
    e.ea = model(to + po, cmv, vo);
    e.eb = model(to + po - 21845, cmv, vo);
    e.ec = model(to + po - 43691, cmv, vo);
    e.cm = cm;
    @(negedge clk);
    theta_out = to[15:0]; phase_ofs = po[15:0]; theta_in = ti[15:0];
    mag = vo[15:0]; cm_en = cm; in_valid = 1'b1;
    e.stamp = cyc;
    e.seq = next_seq;
    seq = next_seq;
    next_seq++;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard whenever a result appears
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R2", "unexpected out_valid", 1, 0);
      end else begin
        exp_t e;
        string t;
        e = sb.pop_front();
        t = e.cm ? "R6" : "R3";
        chk(cyc - e.stamp == 3, "R2", "latency", cyc - e.stamp, 3);
        chk(iabs(int'(ref_a) - int'(e.ea)) <= TOL, t, "ref_a", int'(ref_a), int'(e.ea));
        chk(iabs(int'(ref_b) - int'(e.eb)) <= TOL, e.cm ? "R6" : "R4", "ref_b", int'(ref_b), int'(e.eb));
        chk(iabs(int'(ref_c) - int'(e.ec)) <= TOL, e.cm ? "R6" : "R4", "ref_c", int'(ref_c), int'(e.ec));
        if (!e.cm && mag <= 16'd32768 && iabs(int'(e.ea)) < 32767 && iabs(int'(e.eb)) < 32767) begin
          // R5: three phases balance when injection is off
          chk(iabs(int'(ref_a) + int'(ref_b) + int'(ref_c)) <= 48, "R5", "phase sum",
              int'(ref_a) + int'(ref_b) + int'(ref_c), 0);
        end
        got_a[e.seq] = int'(ref_a);
        got_b[e.seq] = int'(ref_b);
        got_c[e.seq] = int'(ref_c);
        popped++;
      end
    end
  end

  initial begin
    int s_off, s_ti, s_on, s_pos, s_neg, s_big, s_tmp;
    int ha, hb, hc;
    repeat (4) @(negedge clk);
    // R1: cleared outputs while held in reset
    chk(!out_valid && ref_a == 0 && ref_b == 0 && ref_c == 0, "R1", "reset outputs",
        int'(ref_a) | int'(ref_b) | int'(ref_c) | int'(out_valid), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!out_valid && ref_a == 0, "R1", "after release", int'(out_valid), 0);

    send(0, 0, 0, 32768, 1'b0, s_tmp);
    idle(1);
    send(8192, 0, 0, 16384, 1'b0, s_tmp);
    idle(2);
    send(30000, 5000, 1234, 20000, 1'b0, s_off);
    send(30000, 5000, 50000, 20000, 1'b0, s_ti);
    send(30000, 5000, 1234, 20000, 1'b1, s_on);
    idle(3);
    // R8: overflow of the unit sum in both directions
    send(5461, 10923, 16384, 32768, 1'b1, s_pos);
    send(16384, 32768, 5461, 32768, 1'b1, s_neg);
    // R9: magnitude near 2.0 clamps the scaled output
    send(16384, 0, 0, 65535, 1'b0, s_big);
    for (int k = 0; k < 16; k++)
      send((k * 4099) % 65536, k * 777, (k * 3001) % 65536, 4000 + k * 1900, k[0], s_tmp);
    idle(8);

    chk(popped == next_seq, "R2", "results drained", popped, next_seq);
    // R6: theta_in ignored while injection is off
    chk(got_a[s_off] == got_a[s_ti] && got_b[s_off] == got_b[s_ti] && got_c[s_off] == got_c[s_ti],
        "R6", "theta_in effect", got_a[s_ti], got_a[s_off]);
    // R7: line differences unchanged by injection
    chk(iabs((got_a[s_on] - got_b[s_on]) - (got_a[s_off] - got_b[s_off])) <= 2, "R7", "a-b",
        got_a[s_on] - got_b[s_on], got_a[s_off] - got_b[s_off]);
    chk(iabs((got_b[s_on] - got_c[s_on]) - (got_b[s_off] - got_c[s_off])) <= 2, "R7", "b-c",
        got_b[s_on] - got_c[s_on], got_b[s_off] - got_c[s_off]);
    chk(got_a[s_pos] == 32767, "R8", "positive unit clamp", got_a[s_pos], 32767);
    chk(got_a[s_neg] == -32768, "R8", "negative unit clamp", got_a[s_neg], -32768);
    chk(got_a[s_big] == 32767, "R9", "output clamp", got_a[s_big], 32767);

    // R10: outputs hold while in_valid stays low and inputs move
    ha = int'(ref_a); hb = int'(ref_b); hc = int'(ref_c);
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      theta_out = theta_out + 16'd3000; theta_in = theta_in + 16'd999;
      mag = mag + 16'd77; cm_en = ~cm_en;
    end
    repeat (4) @(negedge clk);
    chk(int'(ref_a) == ha && int'(ref_b) == hb && int'(ref_c) == hc && !out_valid,
        "R10", "hold", int'(ref_a), ha);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", popped, next_seq);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule